// File: doc/BRIEF.md
# Timing-Speculative Pipeline with Shadow-Sample Recovery

This block is an in-order pipeline of `STAGES` stages. Each stage register is built as a pair. A main register captures the stage input at the aggressive clock edge. A shadow register keeps the safe capture of the same value. The shadow copy is the reference. When the two copies of a valid stage disagree, the stage has suffered a timing error. The pipeline then repairs itself in place instead of being clocked for the worst case.

Items enter from an instruction-memory-like source. The block presents an index on `fetchIdx`, and the environment answers in the same cycle with the word on `fetchData`. Stage `j` (counted from 0 at the fetch end) adds `j+1` to the word it receives, and the last stage drives the output port.

Recovery follows a mismatch in the cycle after it, and it takes one edge. The oldest failing stage takes its shadow value back. The stage just downstream of it receives a bubble. Every upstream stage is cleared, and fetch stalls for that edge. Fetch then resumes at the item that follows the repaired one, so the output stream keeps its order with nothing lost and nothing repeated.

A test hook, `lateMask`, models data that arrives late. A saturating counter counts recovery events, and an input clears it.

Top module: `spec_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets. After that edge `outValid`, `timingErr`, `errCount` and `fetchIdx` are all zero.
- R2: The item fetched at index i with word w leaves the pipeline with `outIdx` = i and `outData` = w + STAGES·(STAGES+1)/2 (modulo 2^DATA_W). Each stage j (counted from 0) adds j+1 to the word.
- R3: `lateMask[j]` models a late input to stage j. If it is high at a normal edge where stage j captures a valid item, that stage's main copy gets bit 0 inverted while the shadow copy stays correct. `timingErr` is then high for the following cycle. If stage j captures no valid item at that edge, `lateMask[j]` has no effect.
- R4: When `timingErr` is high, the next edge is a recovery edge, and the stage with the highest index among the failing stages is the one repaired. It takes its shadow value, the stage after it becomes empty, and all stages before it are emptied. `fetchIdx` becomes the repaired item's index plus one. `timingErr` is low in the cycle after a recovery edge.
- R5: Output items appear in strictly increasing index order starting at 0, with no gap and no repeat. `outValid` stays low while the last stage holds a failing value.
- R6: `lateMask` is ignored at a recovery edge.
- R7: `errCount` increases by exactly one at each recovery edge, saturates at 2^CNT_W−1, and otherwise holds.
- R8: `cntClear` high at an edge sets `errCount` to zero, even when that edge is also a recovery edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchIdx | output | IDX_W | Index of the item requested from the source |
| fetchData | input | DATA_W | Word for `fetchIdx`, returned in the same cycle |
| lateMask | input | STAGES | Per-stage late-data injection hook |
| cntClear | input | 1 | Clears the error counter |
| outValid | output | 1 | Output item is valid |
| outIdx | output | IDX_W | Index of the output item |
| outData | output | DATA_W | Processed word of the output item |
| timingErr | output | 1 | A timing error is pending; the next edge recovers |
| errCount | output | CNT_W | Saturating count of recovery events |

## Verification
The bench uses several injection patterns:
- A long random run sprinkles late-data injections over every stage. It shows that the stream stays ordered and complete whichever stage fails.
- Single directed injections at the first, middle and last stage each show a different restart index, which tells the three flush depths apart.
- A two-stage injection in one cycle shows that the oldest stage wins.
- An injection held through the recovery edge shows that the hook is ignored there.
- An injection into empty stages just after reset shows that invalid stages never raise an error.

Repeated errors drive the counter to saturation, and a clear that lands on a recovery edge shows which of the two wins.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic recover;   // this edge is a recovery edge
    logic fetchEn;   // stage 0 may take a new item
  } tsp_ctrl_t;
endpackage

// File: rtl/spec_pipe_datapath.sv
`timescale 1ns/1ps
module spec_pipe_datapath
  import tsp_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  tsp_ctrl_t                       ctrl,
  input  logic [STAGES-1:0]               fixMask,
  input  logic [STAGES-1:0]               flushMask,
  input  logic [STAGES-1:0]               bubbleMask,
  input  logic [IDX_W-1:0]                fetchIdx,
  input  logic [DATA_W-1:0]               fetchData,
  input  logic [STAGES-1:0]               lateMask,
  output logic [STAGES-1:0]               errVec,
  output logic [STAGES-1:0][IDX_W-1:0]    stageIdx,
  output logic                            outValid,
  output logic [IDX_W-1:0]                outIdx,
  output logic [DATA_W-1:0]               outData
);

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    logic              validQ;
    logic [IDX_W-1:0]  idxQ;
    logic [DATA_W-1:0] mainQ;
    logic [DATA_W-1:0] shadowQ;
    logic              srcValid;
    logic [IDX_W-1:0]  srcIdx;
    logic [DATA_W-1:0] srcData;
    logic [DATA_W-1:0] calc;
    logic [DATA_W-1:0] lateFlip;

    if (j == 0) begin : g_head
      assign srcValid = ctrl.fetchEn;
      assign srcIdx   = fetchIdx;
      assign srcData  = fetchData;
    end else begin : g_body
      assign srcValid = g_stage[j-1].validQ;
      assign srcIdx   = g_stage[j-1].idxQ;
      assign srcData  = g_stage[j-1].mainQ;
    end

    assign calc     = srcData + DATA_W'(j + 1);
    assign lateFlip = {{(DATA_W-1){1'b0}}, lateMask[j] & srcValid};

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ  <= 1'b0;
        idxQ    <= '0;
        mainQ   <= '0;
        shadowQ <= '0;
      end else if (ctrl.recover) begin
        if (flushMask[j] || bubbleMask[j]) begin
          validQ <= 1'b0;
        end else if (fixMask[j]) begin
          mainQ <= shadowQ;
        end else begin
          validQ  <= srcValid;
          idxQ    <= srcIdx;
          mainQ   <= calc;
          shadowQ <= calc;
        end
      end else begin
        validQ  <= srcValid;
        idxQ    <= srcIdx;
        shadowQ <= calc;
        mainQ   <= calc ^ lateFlip;
      end
    end

    assign errVec[j]   = validQ && (mainQ != shadowQ);
    assign stageIdx[j] = idxQ;

    // R4
    fix_restores_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl.recover && fixMask[j]) |=> (validQ && mainQ == shadowQ));
  end

  assign outValid = g_stage[STAGES-1].validQ && !errVec[STAGES-1];
  assign outIdx   = g_stage[STAGES-1].idxQ;
  assign outData  = g_stage[STAGES-1].mainQ;

endmodule

// File: rtl/spec_pipe_ctrl.sv
`timescale 1ns/1ps
module spec_pipe_ctrl
  import tsp_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [STAGES-1:0]             errVec,
  input  logic [STAGES-1:0][IDX_W-1:0]  stageIdx,
  input  logic                          cntClear,
  output tsp_ctrl_t                     ctrl,
  output logic [STAGES-1:0]             fixMask,
  output logic [STAGES-1:0]             flushMask,
  output logic [STAGES-1:0]             bubbleMask,
  output logic [IDX_W-1:0]              fetchIdx,
  output logic [CNT_W-1:0]              errCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             recover;
  logic [IDX_W-1:0] selIdx;

  // oldest failing stage (highest index) wins
  always_comb begin
    fixMask = '0;
    selIdx  = '0;
    for (int j = 0; j < STAGES; j++) begin
      if (errVec[j]) begin
        fixMask = STAGES'(1) << j;
        selIdx  = stageIdx[j];
      end
    end
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int j = STAGES - 1; j >= 0; j--) begin
      flushMask[j] = seen;
      seen = seen | fixMask[j];
    end
  end

  assign bubbleMask   = fixMask << 1;
  assign recover      = |errVec;
  assign ctrl.recover = recover;
  assign ctrl.fetchEn = !recover;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchIdx <= '0;
    end else if (recover) begin
      fetchIdx <= selIdx + IDX_W'(1);
    end else begin
      fetchIdx <= fetchIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cntClear) begin
      errCount <= '0;
    end else if (recover && errCount != CNT_MAX) begin
      errCount <= errCount + CNT_W'(1);
    end
  end

  // R4
  single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    recover |=> (errVec == '0));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (recover && !cntClear && errCount != CNT_MAX) |=> (errCount == $past(errCount) + CNT_W'(1)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!recover && !cntClear) |=> $stable(errCount));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cntClear |=> (errCount == '0));

endmodule

// File: rtl/spec_pipe.sv
`timescale 1ns/1ps
module spec_pipe
  import tsp_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [IDX_W-1:0]  fetchIdx,
  input  logic [DATA_W-1:0] fetchData,
  input  logic [STAGES-1:0] lateMask,
  input  logic              cntClear,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData,
  output logic              timingErr,
  output logic [CNT_W-1:0]  errCount
);

  tsp_ctrl_t                      ctrl;
  logic [STAGES-1:0]              fixMask;
  logic [STAGES-1:0]              flushMask;
  logic [STAGES-1:0]              bubbleMask;
  logic [STAGES-1:0]              errVec;
  logic [STAGES-1:0][IDX_W-1:0]   stageIdx;

  spec_pipe_ctrl #(.STAGES(STAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .errVec     (errVec),
    .stageIdx   (stageIdx),
    .cntClear   (cntClear),
    .ctrl       (ctrl),
    .fixMask    (fixMask),
    .flushMask  (flushMask),
    .bubbleMask (bubbleMask),
    .fetchIdx   (fetchIdx),
    .errCount   (errCount)
  );

  spec_pipe_datapath #(.STAGES(STAGES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .fixMask    (fixMask),
    .flushMask  (flushMask),
    .bubbleMask (bubbleMask),
    .fetchIdx   (fetchIdx),
    .fetchData  (fetchData),
    .lateMask   (lateMask),
    .errVec     (errVec),
    .stageIdx   (stageIdx),
    .outValid   (outValid),
    .outIdx     (outIdx),
    .outData    (outData)
  );

  assign timingErr = ctrl.recover;

endmodule

// File: tb/spec_pipe_test.sv
`timescale 1ns/1ps
module spec_pipe_test;
  localparam int S   = 3;
  localparam int DW  = 16;
  localparam int IW  = 16;
  localparam int CW  = 3;
  localparam int SUM = S * (S + 1) / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] fetchIdx;
  logic [DW-1:0] fetchData;
  logic [S-1:0]  lateMask = '0;
  logic          cntClear = 1'b0;
  logic          outValid;
  logic [IW-1:0] outIdx;
  logic [DW-1:0] outData;
  logic          timingErr;
  logic [CW-1:0] errCount;

  int checks = 0;
  int fails  = 0;
  logic [IW-1:0] expNext  = '0;
  logic [CW-1:0] cntModel = '0;
  logic [IW-1:0] seenIdx;
  logic          errNow;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] srcWord(logic [IW-1:0] i);
    return DW'(i * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign fetchData = srcWord(fetchIdx);

  spec_pipe #(.STAGES(S), .DATA_W(DW), .IDX_W(IW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .fetchIdx(fetchIdx), .fetchData(fetchData),
    .lateMask(lateMask), .cntClear(cntClear), .outValid(outValid),
    .outIdx(outIdx), .outData(outData), .timingErr(timingErr), .errCount(errCount)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: observe at negedge, then drive inputs for the next edge
  task automatic cycle(input logic [S-1:0] lm, input logic clr);
    @(negedge clk);
    if (outValid) begin
      check(outIdx == expNext, "R5 order", 32'(outIdx), 32'(expNext));
      check(outData == srcWord(expNext) + DW'(SUM), "R2 data", 32'(outData), 32'(srcWord(expNext) + DW'(SUM)));
      expNext = expNext + 1'b1;
    end
    check(errCount == cntModel, "R7 count", 32'(errCount), 32'(cntModel));
    seenIdx  = fetchIdx;
    errNow   = timingErr;
    lateMask = lm;
    cntClear = clr;
    if (clr) cntModel = '0;
    else if (errNow && cntModel != {CW{1'b1}}) cntModel = cntModel + 1'b1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // single injection test, expects restart at p + offset
  task automatic injectOne(input logic [S-1:0] lm, input int offs, input string tag);
    logic [IW-1:0] p;
    repeat (6) cycle('0, 1'b0);
    cycle(lm, 1'b0);
    p = seenIdx;
    cycle('0, 1'b0);
    check(timingErr == 1'b1, {tag, " R3 flag"}, 32'(timingErr), 1);
    cycle('0, 1'b0);
    check(timingErr == 1'b0, {tag, " R4 one cycle"}, 32'(timingErr), 0);
    check(fetchIdx == IW'(int'(p) + offs), {tag, " R4 restart"}, 32'(fetchIdx), 32'(int'(p) + offs));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [IW-1:0] p;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", 32'(outValid), 0);
    check(timingErr == 1'b0, "R1 timingErr", 32'(timingErr), 0);
    check(errCount == '0, "R1 errCount", 32'(errCount), 0);
    check(fetchIdx == '0, "R1 fetchIdx", 32'(fetchIdx), 0);
    rst = 1'b0;
    // R3: injection into empty stages has no effect
    lateMask = 3'b110;
    cycle('0, 1'b0);
    check(timingErr == 1'b0, "R3 empty stage", 32'(timingErr), 0);
    check(fetchIdx == 1, "R2 fetch step", 32'(fetchIdx), 1);

    // directed stage errors: restart index depends on depth (R4)
    injectOne(3'b001, 1,  "s0");
    injectOne(3'b010, 0,  "s1");
    injectOne(3'b100, -1, "s2");
    injectOne(3'b101, -1, "s2+s0 oldest");

    // R6: hook held high at the recovery edge is ignored
    repeat (6) cycle('0, 1'b0);
    cycle(3'b001, 1'b0);
    p = seenIdx;
    cycle(3'b111, 1'b0);
    check(timingErr == 1'b1, "R6 first error", 32'(timingErr), 1);
    cycle('0, 1'b0);
    check(timingErr == 1'b0, "R6 ignored at recovery", 32'(timingErr), 0);
    check(fetchIdx == p + 1'b1, "R6 restart", 32'(fetchIdx), 32'(p + 1'b1));

    // R7 saturation
    for (int k = 0; k < 10; k++) begin
      cycle(3'b100, 1'b0);
      cycle('0, 1'b0);
      cycle('0, 1'b0);
    end
    check(errCount == {CW{1'b1}}, "R7 saturate", 32'(errCount), 32'({CW{1'b1}}));

    // R8 clear wins over a recovery on the same edge
    cycle(3'b010, 1'b0);
    cycle('0, 1'b1);
    check(timingErr == 1'b1, "R8 setup", 32'(timingErr), 1);
    cycle('0, 1'b0);
    check(errCount == '0, "R8 clear wins", 32'(errCount), 0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [S-1:0] lm;
      for (int b = 0; b < S; b++) lm[b] = ($urandom_range(0, 7) == 0);
      cycle(lm, $urandom_range(0, 63) == 0);
    end

    // drain and check nothing was lost or repeated (R5)
    repeat (8) cycle('0, 1'b0);
    check(expNext == fetchIdx - IW'(S - 1), "R5 no loss", 32'(expNext), 32'(fetchIdx - IW'(S - 1)));
    report();
    $finish;
  end
endmodule